// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave

This block is the configuration front end of a programmable clock generator. It is a two-wire serial slave that holds a bank of byte-wide registers and drives them in parallel onto the chip. Both bus lines are oversampled in the system clock domain. The data line is open drain: the block drives an enable that pulls the line low and reads the resolved line back.

A master loads the registers only with block writes. A write carries the address with the write bit, then a command byte, then a length byte, then the data. The block ignores the values of the command and length bytes. Data always fills the registers in order, starting at register 0, and every complete byte received before a Stop is kept. Two register pairs hold multi-byte settings. A pair changes only when both of its bytes arrive in the same transaction. If the transaction ends between the two bytes, the pair keeps its old value.

A block read returns a length byte and then the registers in order from register 0. The length comes from a writable count register. The identification register is fixed in the logic and cannot be written.

Top module: `cfg_slave`

## Requirements
- R1: The slave acknowledges a transaction whose 7-bit address equals DEV_ADDR (default 69h). It does not acknowledge any other address, and such a transaction changes no register.
- R2: In a write, the two bytes after the address (a command byte and a length byte) are acknowledged and their values are discarded. The next byte is written to register 0.
- R3: Each later data byte goes to the next register index. When a Stop follows any complete data byte, every byte acknowledged before that Stop is stored, and registers that were not reached keep their values.
- R4: Registers 9/10 and 11/12 form pairs. The first byte of a pair is held aside. Both registers of the pair change only on the cycle after the second byte is taken. A transaction that ends after the first byte leaves both registers unchanged.
- R5: Register 8 is the readback count and resets to 08h. A write of 00h to it is ignored, so it never holds zero.
- R6: Register 7 reads as the constant 92h: vendor nibble 1001b in bits 7:4 and revision 2h in bits 3:0. Writes to it are discarded, but they still advance the register index.
- R7: A read transaction returns first the value of register 8 (N), then registers 0, 1, … up to N bytes, each byte MSB first.
- R8: During a read, the slave releases SDA once N data bytes have been sent or the master NACKs a byte. Any further clocked bits then read as 1. SDA changes only while the synchronised SCL is low.
- R9: Synchronous reset sets register 7 to 92h, register 8 to 08h and every other register to 00h, and releases SDA.
- R10: A repeated Start inside a write restarts the framing. The next data byte goes again to register 0, and a pair whose first byte was pending is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Resolved serial data line as seen at the pin |
| sda_oe | output | 1 | When high, the block pulls the data line low |
| cfg_q | output | NREG*8 | All register contents; register i is in bits i*8+7:i*8 |

## Verification
The hardest case to reach is an incomplete pair. The pair must be abandoned exactly between its two bytes, either by a Stop or by a repeated Start, and only after enough data bytes to reach register 9 or 11. The bench drives block writes of chosen length that end at exactly those points, the second one through a repeated Start followed by a fresh one-byte write. It then confirms at the register outputs that the pair kept its old value while register 0 took the new byte. Reads are also run past the programmed length and past an early NACK, so the released data line is seen as all-ones bytes.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          CNT_IDX     = 8;
    localparam int          ID_IDX      = 7;
    localparam logic [3:0]  VENDOR_ID   = 4'b1001;
    localparam logic [3:0]  REV_ID      = 4'h2;
    localparam logic [7:0]  CNT_DEFAULT = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_st_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_CMD,
        BK_LEN,
        BK_DATA
    } byte_kind_e;

    // Synchronised line levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // One completed data byte headed for the register bank
    typedef struct packed {
        logic                en;
        logic [7:0]          idx;
        logic [BYTE_W-1:0]   data;
    } wr_req_t;

    function automatic logic [7:0] reg_default(input int i);
        if (i == ID_IDX)       return {VENDOR_ID, REV_ID};
        else if (i == CNT_IDX) return CNT_DEFAULT;
        else                   return 8'h00;
    endfunction

    function automatic logic is_pair_lo(input int i);
        return (i == 9) || (i == 11);
    endfunction

    function automatic logic is_pair_hi(input int i);
        return (i == 10) || (i == 12);
    endfunction

endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync
    import cfgslv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] rd_data,
    input  logic [7:0] cnt_val,
    output logic [7:0] rd_idx,
    output wr_req_t    wr,
    output logic       sda_oe
);
    bus_st_e    st;
    byte_kind_e kind;
    logic [3:0] bit_cnt;
    logic [7:0] sh;
    logic [7:0] wr_idx;
    logic [7:0] left;
    logic       rw;
    logic       nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind    <= BK_ADDR;
            bit_cnt <= '0;
            sh      <= '0;
            wr_idx  <= '0;
            rd_idx  <= '0;
            left    <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                st      <= ST_RX;
                kind    <= BK_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise) begin
                            sh      <= {sh[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.fall && bit_cnt == 4'd8) begin
                            if (kind != BK_ADDR || sh[7:1] == DEV_ADDR) begin
                                st     <= ST_ACK;
                                sda_oe <= 1'b1;
                                if (kind == BK_ADDR) rw <= sh[0];
                                if (kind == BK_DATA) begin
                                    wr.en   <= 1'b1;
                                    wr.idx  <= wr_idx;
                                    wr.data <= sh;
                                end
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            if (kind == BK_ADDR && rw) begin
                                st     <= ST_TX;
                                sh     <= cnt_val;
                                sda_oe <= ~cnt_val[7];
                                left   <= cnt_val;
                                rd_idx <= '0;
                            end else begin
                                st <= ST_RX;
                                case (kind)
                                    BK_ADDR: kind <= BK_CMD;
                                    BK_CMD:  kind <= BK_LEN;
                                    BK_LEN: begin
                                        kind   <= BK_DATA;
                                        wr_idx <= '0;
                                    end
                                    default: if (wr_idx != 8'hFF) wr_idx <= wr_idx + 8'd1;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (bit_cnt == 4'd7) begin
                                st     <= ST_RACK;
                                sda_oe <= 1'b0;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                sh      <= {sh[6:0], 1'b0};
                                sda_oe  <= ~sh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            nack <= ev.sda;
                        end else if (ev.fall) begin
                            if (nack || left == 8'd0) begin
                                st <= ST_IDLE;
                            end else begin
                                st      <= ST_TX;
                                bit_cnt <= '0;
                                sh      <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                rd_idx  <= rd_idx + 8'd1;
                                left    <= left - 8'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfgslv_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic              abort,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic [7:0]        cnt_val,
    output logic [NREG*8-1:0] q
);
    localparam int IW = $clog2(NREG);

    logic [7:0] qa [NREG];
    logic [7:0] shadow;
    logic [7:0] shadow_idx;
    logic       shadow_vld;
    logic       commit;

    assign commit = wr.en && is_pair_hi(int'(wr.idx)) && shadow_vld
                    && (shadow_idx == wr.idx - 8'd1);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            shadow_vld <= 1'b0;
            if (rst) begin
                shadow     <= '0;
                shadow_idx <= '0;
            end
        end else if (wr.en && is_pair_lo(int'(wr.idx))) begin
            shadow     <= wr.data;
            shadow_idx <= wr.idx;
            shadow_vld <= 1'b1;
        end else if (wr.en) begin
            shadow_vld <= 1'b0;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == ID_IDX) begin : g_ro
            assign qa[i] = reg_default(i);
        end else if (is_pair_lo(i)) begin : g_lo
            logic [7:0] r;
            always_ff @(posedge clk) begin
                if (rst)                                  r <= reg_default(i);
                else if (commit && shadow_idx == 8'(i))   r <= shadow;
            end
            assign qa[i] = r;
        end else if (is_pair_hi(i)) begin : g_hi
            logic [7:0] r;
            always_ff @(posedge clk) begin
                if (rst)                               r <= reg_default(i);
                else if (commit && wr.idx == 8'(i))    r <= wr.data;
            end
            assign qa[i] = r;
        end else begin : g_rw
            logic [7:0] r;
            logic       hit;
            assign hit = wr.en && (wr.idx == 8'(i));
            always_ff @(posedge clk) begin
                if (rst)                                            r <= reg_default(i);
                else if (hit && !(i == CNT_IDX && wr.data == 8'h00)) r <= wr.data;
            end
            assign qa[i] = r;
        end
        assign q[i*8 +: 8] = qa[i];
    end

    assign rd_data = (rd_idx < 8'(NREG)) ? qa[rd_idx[IW-1:0]] : 8'h00;
    assign cnt_val = qa[CNT_IDX];

endmodule

// File: rtl/cfg_slave.sv
module cfg_slave
    import cfgslv_pkg::*;
#(
    parameter int         NREG     = 16,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_q
);
    bus_ev_t    bus_ev;
    wr_req_t    wr_req;
    logic [7:0] rd_idx;
    logic [7:0] rd_data;
    logic [7:0] cnt_val;
    logic       scl_s;
    logic       wr_en;
    logic [7:0] wr_idx;

    cfg_bus_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    cfg_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (bus_ev),
        .rd_data (rd_data),
        .cnt_val (cnt_val),
        .rd_idx  (rd_idx),
        .wr      (wr_req),
        .sda_oe  (sda_oe)
    );

    cfg_regbank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .abort   (bus_ev.start | bus_ev.stop),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cnt_val (cnt_val),
        .q       (cfg_q)
    );

    assign scl_s  = bus_ev.scl;
    assign wr_en  = wr_req.en;
    assign wr_idx = wr_req.idx;

endmodule

// File: rtl/cfg_slave_chk.sv
module cfg_slave_chk
    import cfgslv_pkg::*;
#(
    parameter int NREG = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [7:0]        wr_idx,
    input logic [NREG*8-1:0] cfg_q
);
    p_id_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_q[ID_IDX*8 +: 8] == {VENDOR_ID, REV_ID});

    p_count_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_q[CNT_IDX*8 +: 8] != 8'h00);

    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_s));

    for (genvar i = 0; i + 1 < NREG; i++) begin : g_pair
        if (is_pair_lo(i)) begin : g_p
            p_pair_lo_r4: assert property (@(posedge clk) disable iff (rst)
                !$stable(cfg_q[i*8 +: 8]) |-> $past(wr_en && wr_idx == 8'(i + 1)));
            p_pair_hi_r4: assert property (@(posedge clk) disable iff (rst)
                !$stable(cfg_q[(i+1)*8 +: 8]) |-> $past(wr_en && wr_idx == 8'(i + 1)));
        end
    end

endmodule

bind cfg_slave cfg_slave_chk #(.NREG(NREG)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_s  (scl_s),
    .sda_oe (sda_oe),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .cfg_q  (cfg_q)
);

// File: tb/tb_cfg_slave.sv
module tb_cfg_slave;
    localparam int         NREG = 16;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int         Q    = 10;

    typedef struct {
        logic [7:0] v;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_q;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_reg [NREG];
    logic [7:0] pay [NREG];
    exp_t       exp_q [$];
    logic [7:0] got;
    event       ev_got;

    always #5 clk = ~clk;

    cfg_slave #(.NREG(NREG), .DEV_ADDR(ADDR)) dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .cfg_q  (cfg_q)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(4 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit m_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!m_ack);
    endtask

    // Model of one write transaction's effect; built from R2..R6
    task automatic model_write(input int n);
        for (int i = 0; i < n && i < NREG; i++) begin
            if (i == 7) begin
            end else if (i == 8) begin
                if (pay[i] != 8'h00) exp_reg[i] = pay[i];
            end else if (i == 9 || i == 11) begin
            end else if (i == 10 || i == 12) begin
                exp_reg[i-1] = pay[i-1];
                exp_reg[i]   = pay[i];
            end else begin
                exp_reg[i] = pay[i];
            end
        end
    endtask

    task automatic write_head(input string req);
        bit ack;
        bus_start();
        send_byte({ADDR, 1'b0}, ack); chk(ack, "R1", 8'(ack), 8'h01);
        send_byte(8'hA5, ack);        chk(ack, req, 8'(ack), 8'h01);
        send_byte(8'h3C, ack);        chk(ack, req, 8'(ack), 8'h01);
    endtask

    task automatic write_block(input int n, input string req);
        bit ack;
        write_head(req);
        for (int i = 0; i < n; i++) send_byte(pay[i], ack);
        bus_stop();
        model_write(n);
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < NREG; i++)
            chk(cfg_q[i*8 +: 8] === exp_reg[i], req, cfg_q[i*8 +: 8], exp_reg[i]);
    endtask

    // Driver: pushes the expected bytes, then clocks them out of the slave
    task automatic read_block(input int n_read, input int nack_at);
        bit ack;
        logic [7:0] d;
        int cnt;
        exp_t e;
        cnt = int'(exp_reg[8]);
        for (int k = 0; k < n_read; k++) begin
            if (k == 0)                     begin e.v = exp_reg[8];   e.req = "R7"; end
            else if (k <= cnt && k <= nack_at) begin e.v = exp_reg[k-1]; e.req = "R7"; end
            else                            begin e.v = 8'hFF;        e.req = "R8"; end
            exp_q.push_back(e);
        end
        bus_start();
        send_byte({ADDR, 1'b1}, ack); chk(ack, "R1", 8'(ack), 8'h01);
        for (int k = 0; k < n_read; k++) begin
            recv_byte(d, k != nack_at);
            got = d;
            -> ev_got;
            wq(2);
        end
        bus_stop();
    endtask

    // Monitor: pops and compares each byte as it is read back
    initial begin
        exp_t e;
        forever begin
            @(ev_got);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", got, 8'hXX);
            end else begin
                e = exp_q.pop_front();
                chk(got === e.v, e.req, got, e.v);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ack;
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
        exp_reg[7] = 8'h92;
        exp_reg[8] = 8'h08;
        wq(5);
        rst = 1'b0;
        wq(5);

        // R9 reset state, R6 id, R5 count default
        compare_all("R9");
        chk(cfg_q[7*8 +: 8] == 8'h92, "R6", cfg_q[7*8 +: 8], 8'h92);
        chk(cfg_q[8*8 +: 8] == 8'h08, "R5", cfg_q[8*8 +: 8], 8'h08);
        chk(sda_oe == 1'b0, "R9", 8'(sda_oe), 8'h00);

        // R2/R3/R4/R6: full write through both pairs, id write discarded
        for (int i = 0; i < NREG; i++) pay[i] = 8'(8'h31 + i * 7);
        pay[7] = 8'h55;
        pay[8] = 8'h04;
        write_block(13, "R2");
        compare_all("R3");

        // R3: stop after 3 bytes, rest untouched
        for (int i = 0; i < NREG; i++) pay[i] = 8'(8'hC0 + i);
        write_block(3, "R3");
        compare_all("R3");

        // R4: stop right after the first byte of pair 9/10
        for (int i = 0; i < NREG; i++) pay[i] = 8'(8'h70 + i);
        pay[8] = 8'h04;
        write_block(10, "R4");
        compare_all("R4");

        // R10: repeated start right after first byte of pair 11/12
        for (int i = 0; i < NREG; i++) pay[i] = 8'(8'hA0 + i);
        pay[8] = 8'h04;
        write_head("R10");
        for (int i = 0; i < 12; i++) send_byte(pay[i], ack);
        model_write(12);
        pay[0] = 8'h5A;
        write_head("R10");
        send_byte(pay[0], ack);
        bus_stop();
        model_write(1);
        compare_all("R10");

        // R5: zero written to the count register is ignored
        for (int i = 0; i < NREG; i++) pay[i] = 8'(8'h11 * (i + 1));
        pay[8] = 8'h00;
        write_block(9, "R5");
        compare_all("R5");
        chk(cfg_q[8*8 +: 8] == 8'h04, "R5", cfg_q[8*8 +: 8], 8'h04);

        // R1: foreign address is not acknowledged, writes nothing
        bus_start();
        send_byte({7'h22, 1'b0}, ack);
        chk(!ack, "R1", 8'(ack), 8'h00);
        send_byte(8'h00, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        compare_all("R1");

        // R7/R8: count 4, read past the end
        read_block(6, 99);

        // R8: count 8, master NACKs the third byte
        for (int i = 0; i < NREG; i++) pay[i] = 8'(8'h21 + i * 3);
        pay[8] = 8'h08;
        write_block(9, "R3");
        compare_all("R3");
        read_block(5, 2);

        wq(20);
        chk(exp_q.size() == 0, "R7", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule